// File: doc/BRIEF.md
# Audio Sample Word Formatter

This block sits between the 32-bit sample FIFOs and the subframe engines of a biphase-mark digital audio port. On the transmit side it takes the word at the head of a show-ahead FIFO. When the line transmitter requests the next subframe, the block turns that word into a 24-bit payload slot. It also produces a P/C/U/V flag nibble and a preamble code, and it decides when the FIFO word has been used up and is popped. On the receive side it takes each decoded subframe from the line receiver, applies the capture-start rule, and builds the 32-bit word that is pushed into the receive FIFO.

A two-bit format selector picks the word layout: 00 is 16-bit, 01 is 20-bit, 10 is 24-bit and 11 is raw. A pack flag, which has effect only with the 16-bit format, places a left and a right sample in one word. Raw format carries the flag bits, the aux nibble and the preamble code in the word itself, so software can build or inspect whole subframes. Line coding, preamble generation and FIFO storage are handled elsewhere.

Top module: `audio_word_fmt`

## Requirements
- R1: Out of synchronous reset, tx_sf_valid, rx_push and tx_word_pop are low, and tx_aud and rx_word are zero.
- R2: In 24-bit format (sel 10) with pack low or high, each subframe request with a word available yields tx_aud = word[23:0], and that word is popped in the same cycle as the request.
- R3: In 20-bit format (sel 01) tx_aud = {word[19:0], 4'h0}. In unpacked 16-bit format (sel 00) tx_aud = {word[15:0], 8'h00}. The unused low payload bits are zero.
- R4: In raw format (sel 11), tx_pcuv = word[31:28], tx_aud = word[27:4] (20 audio bits above the aux nibble) and tx_pre = word[3:0]. In every other format tx_pcuv and tx_pre are zero.
- R5: In packed 16-bit format, a left request (sf_req_left = 1) emits {word[15:0], 8'h00} and a right request emits {word[31:16], 8'h00}.
- R6: In packed format a word is popped only on the request that uses its second distinct half. This holds whether the left half or the right half is taken first.
- R7: The pack flag is ignored unless the format is 16-bit, on both the transmit and the receive side.
- R8: tx_sf_valid is high for one cycle, in the cycle after a request that found a word available. A request with no word available gives no strobe and no pop.
- R9: On receive in 16, 20 and 24-bit unpacked formats, rx_word = {pcuv, preamble, sample}. The sample is the top 16, 20 or 24 bits of rx_aud, right-aligned at bit 0 and zero-extended up to bit 23.
- R10: On receive in raw format, rx_word = {pcuv, rx_aud[23:0], preamble}.
- R11: After cap_en rises, subframes are dropped until the first subframe whose side matches cap_start_left (1 = left, 0 = right). From then on every subframe is accepted.
- R12: In packed receive, a word is pushed only when a subframe of the opposite side follows a held one. The left sample goes in bits 15:0 and the right sample in bits 31:16, each taken from rx_aud[23:8].
- R13: While cap_en is low nothing is pushed, and a half-built packed pair is discarded.
- R14: rx_push is high for one cycle, in the cycle after the accepted subframe strobe that completes a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Word format: 00 16-bit, 01 20-bit, 10 24-bit, 11 raw |
| pack_en | input | 1 | Two 16-bit samples per word (16-bit format only) |
| cap_en | input | 1 | Receive capture enable |
| cap_start_left | input | 1 | Capture begins on a left (1) or right (0) subframe |
| tx_word | input | 32 | Head word of the transmit FIFO |
| tx_word_avail | input | 1 | Transmit FIFO holds a word |
| tx_word_pop | output | 1 | Remove the head word (combinational, same cycle as request) |
| sf_req | input | 1 | Transmitter requests the next subframe payload |
| sf_req_left | input | 1 | Requested subframe is left (1) or right (0) |
| tx_sf_valid | output | 1 | Payload outputs are valid this cycle |
| tx_aud | output | 24 | Transmit payload slot, MSB is the sample MSB |
| tx_pcuv | output | 4 | Transmit parity, channel status, user, validity (raw only) |
| tx_pre | output | 4 | Transmit preamble code (raw only) |
| rx_sf_valid | input | 1 | Receiver delivers a decoded subframe |
| rx_sf_left | input | 1 | Delivered subframe is left (1) or right (0) |
| rx_aud | input | 24 | Received payload slot |
| rx_pcuv | input | 4 | Received parity, channel status, user, validity |
| rx_pre | input | 4 | Received preamble code |
| rx_push | output | 1 | Push rx_word into the receive FIFO |
| rx_word | output | 32 | Assembled receive word |

## Verification
Each transmit payload is due in the cycle that follows its request. Each receive word is due in the cycle that follows the subframe strobe that completes it. The FIFO pop is combinational, so it counts in the same cycle as the request. The bench drives one request or strobe per task call and samples at the next falling edge. There it checks the strobe level directly, and a scoreboard queue supplies the expected payload or word. Pops are counted at the rising edge by a FIFO model in the bench and compared at the falling edge after each request, which pins down the pop cycle in packed mode. Dropped or discarded subframes are checked by a low rx_push at the due edge and by an empty scoreboard at the end.

// File: rtl/awf_pkg.sv
package awf_pkg;
  localparam int WORD_W = 32;
  localparam int PAY_W  = 24;
  localparam int FLAG_W = 4;
  localparam int PRE_W  = 4;

  typedef enum logic [1:0] {
    FMT_16  = 2'b00,
    FMT_20  = 2'b01,
    FMT_24  = 2'b10,
    FMT_RAW = 2'b11
  } fmt_e;
endpackage

// File: rtl/awf_tx_unpack.sv
module awf_tx_unpack
  import awf_pkg::*;
#(
  parameter int WORD_W = awf_pkg::WORD_W,
  parameter int PAY_W  = awf_pkg::PAY_W,
  parameter int FLAG_W = awf_pkg::FLAG_W,
  parameter int PRE_W  = awf_pkg::PRE_W,
  parameter int S20_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        fmt_i,
  input  logic              pack_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              pop_o,
  input  logic              req_i,
  input  logic              left_i,
  output logic              sf_valid_o,
  output logic [PAY_W-1:0]  aud_o,
  output logic [FLAG_W-1:0] pcuv_o,
  output logic [PRE_W-1:0]  pre_o
);
  localparam int HALF_W = WORD_W / 2;
  localparam int PAD16  = PAY_W - HALF_W;
  localparam int PAD20  = PAY_W - S20_W;

  logic              packed_eff;
  logic              take;
  logic              other_used;
  logic [1:0]        used_r;   // bit0: left half taken, bit1: right half taken
  logic [HALF_W-1:0] half_sel;
  logic [PAY_W-1:0]  aud_n;
  logic [FLAG_W-1:0] pcuv_n;
  logic [PRE_W-1:0]  pre_n;

  assign packed_eff = pack_i && (fmt_i == FMT_16);
  assign take       = req_i && word_valid_i;
  assign other_used = left_i ? used_r[1] : used_r[0];
  assign pop_o      = take && (!packed_eff || other_used);
  assign half_sel   = left_i ? word_i[HALF_W-1:0] : word_i[WORD_W-1:HALF_W];

  always_comb begin
    pcuv_n = '0;
    pre_n  = '0;
    case (fmt_i)
      FMT_16:  aud_n = {(packed_eff ? half_sel : word_i[HALF_W-1:0]), {PAD16{1'b0}}};
      FMT_20:  aud_n = {word_i[S20_W-1:0], {PAD20{1'b0}}};
      FMT_24:  aud_n = word_i[PAY_W-1:0];
      default: begin
        aud_n  = word_i[PRE_W +: PAY_W];
        pcuv_n = word_i[WORD_W-1 -: FLAG_W];
        pre_n  = word_i[PRE_W-1:0];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sf_valid_o <= 1'b0;
      aud_o      <= '0;
      pcuv_o     <= '0;
      pre_o      <= '0;
      used_r     <= '0;
    end else begin
      sf_valid_o <= take;
      if (take) begin
        aud_o  <= aud_n;
        pcuv_o <= pcuv_n;
        pre_o  <= pre_n;
      end
      if (!packed_eff) begin
        used_r <= '0;
      end else if (take) begin
        if (pop_o) used_r <= '0;
        else if (left_i) used_r[0] <= 1'b1;
        else used_r[1] <= 1'b1;
      end
    end
  end

  // R8
  strobe_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && word_valid_i) |=> sf_valid_o);

  // R8
  no_pop_without_word_chk: assert property (@(posedge clk) disable iff (rst)
    !word_valid_i |-> !pop_o);

  // R3
  low_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sf_valid_o && $past(fmt_i) == FMT_16) |-> (aud_o[PAD16-1:0] == '0));

  // R6
  packed_pop_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (packed_eff && pop_o) |-> (used_r != 2'b00));
endmodule

// File: rtl/awf_cap_gate.sv
module awf_cap_gate (
  input  logic clk,
  input  logic rst,
  input  logic cap_en_i,
  input  logic start_left_i,
  input  logic sf_valid_i,
  input  logic left_i,
  output logic accept_o
);
  logic synced_r;

  assign accept_o = sf_valid_i && cap_en_i && (synced_r || (left_i == start_left_i));

  always_ff @(posedge clk) begin
    if (rst || !cap_en_i) synced_r <= 1'b0;
    else if (accept_o)    synced_r <= 1'b1;
  end

  // R11
  synced_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_en_i |=> !synced_r);
endmodule

// File: rtl/awf_rx_pack.sv
module awf_rx_pack
  import awf_pkg::*;
#(
  parameter int WORD_W = awf_pkg::WORD_W,
  parameter int PAY_W  = awf_pkg::PAY_W,
  parameter int FLAG_W = awf_pkg::FLAG_W,
  parameter int PRE_W  = awf_pkg::PRE_W,
  parameter int S20_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        fmt_i,
  input  logic              pack_i,
  input  logic              cap_en_i,
  input  logic              sf_valid_i,
  input  logic              accept_i,
  input  logic              left_i,
  input  logic [PAY_W-1:0]  aud_i,
  input  logic [FLAG_W-1:0] pcuv_i,
  input  logic [PRE_W-1:0]  pre_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int HALF_W = WORD_W / 2;
  localparam int HDR_W  = FLAG_W + PRE_W;
  localparam int ZP16   = WORD_W - HDR_W - HALF_W;
  localparam int ZP20   = WORD_W - HDR_W - S20_W;

  logic              packed_eff;
  logic              hold_v;
  logic              hold_left;
  logic [HALF_W-1:0] hold_half;
  logic [HALF_W-1:0] half_in;
  logic              pair_done;
  logic [WORD_W-1:0] flat_w;
  logic [WORD_W-1:0] pair_w;

  assign packed_eff = pack_i && (fmt_i == FMT_16);
  assign half_in    = aud_i[PAY_W-1 -: HALF_W];
  assign pair_done  = hold_v && (hold_left != left_i);
  assign pair_w     = left_i ? {hold_half, half_in} : {half_in, hold_half};

  always_comb begin
    case (fmt_i)
      FMT_16:  flat_w = {pcuv_i, pre_i, {ZP16{1'b0}}, aud_i[PAY_W-1 -: HALF_W]};
      FMT_20:  flat_w = {pcuv_i, pre_i, {ZP20{1'b0}}, aud_i[PAY_W-1 -: S20_W]};
      FMT_24:  flat_w = {pcuv_i, pre_i, aud_i};
      default: flat_w = {pcuv_i, aud_i, pre_i};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      push_o    <= 1'b0;
      word_o    <= '0;
      hold_v    <= 1'b0;
      hold_left <= 1'b0;
      hold_half <= '0;
    end else begin
      push_o <= 1'b0;
      if (!cap_en_i || !packed_eff) hold_v <= 1'b0;
      if (accept_i) begin
        if (packed_eff) begin
          if (pair_done) begin
            push_o <= 1'b1;
            word_o <= pair_w;
            hold_v <= 1'b0;
          end else begin
            hold_v    <= 1'b1;
            hold_left <= left_i;
            hold_half <= half_in;
          end
        end else begin
          push_o <= 1'b1;
          word_o <= flat_w;
        end
      end
    end
  end

  // R14
  push_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    push_o |-> $past(sf_valid_i));

  // R13
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_en_i |=> !push_o);

  // R12
  packed_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (push_o && $past(packed_eff)) |-> $past(hold_v));
endmodule

// File: rtl/audio_word_fmt.sv
module audio_word_fmt
  import awf_pkg::*;
#(
  parameter int WORD_W = awf_pkg::WORD_W,
  parameter int PAY_W  = awf_pkg::PAY_W,
  parameter int FLAG_W = awf_pkg::FLAG_W,
  parameter int PRE_W  = awf_pkg::PRE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        fmt_sel,
  input  logic              pack_en,
  input  logic              cap_en,
  input  logic              cap_start_left,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_word_avail,
  output logic              tx_word_pop,
  input  logic              sf_req,
  input  logic              sf_req_left,
  output logic              tx_sf_valid,
  output logic [PAY_W-1:0]  tx_aud,
  output logic [FLAG_W-1:0] tx_pcuv,
  output logic [PRE_W-1:0]  tx_pre,
  input  logic              rx_sf_valid,
  input  logic              rx_sf_left,
  input  logic [PAY_W-1:0]  rx_aud,
  input  logic [FLAG_W-1:0] rx_pcuv,
  input  logic [PRE_W-1:0]  rx_pre,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_word
);
  logic rx_accept;

  awf_tx_unpack #(.WORD_W(WORD_W), .PAY_W(PAY_W), .FLAG_W(FLAG_W), .PRE_W(PRE_W)) tx_u (
    .clk(clk), .rst(rst), .fmt_i(fmt_sel), .pack_i(pack_en),
    .word_i(tx_word), .word_valid_i(tx_word_avail), .pop_o(tx_word_pop),
    .req_i(sf_req), .left_i(sf_req_left), .sf_valid_o(tx_sf_valid),
    .aud_o(tx_aud), .pcuv_o(tx_pcuv), .pre_o(tx_pre)
  );

  awf_cap_gate gate_u (
    .clk(clk), .rst(rst), .cap_en_i(cap_en), .start_left_i(cap_start_left),
    .sf_valid_i(rx_sf_valid), .left_i(rx_sf_left), .accept_o(rx_accept)
  );

  awf_rx_pack #(.WORD_W(WORD_W), .PAY_W(PAY_W), .FLAG_W(FLAG_W), .PRE_W(PRE_W)) rx_u (
    .clk(clk), .rst(rst), .fmt_i(fmt_sel), .pack_i(pack_en), .cap_en_i(cap_en),
    .sf_valid_i(rx_sf_valid), .accept_i(rx_accept), .left_i(rx_sf_left),
    .aud_i(rx_aud), .pcuv_i(rx_pcuv), .pre_i(rx_pre),
    .push_o(rx_push), .word_o(rx_word)
  );
endmodule

// File: tb/audio_word_fmt_tb_top.sv
module audio_word_fmt_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmt_sel = 2'b10;
  logic        pack_en = 1'b0;
  logic        cap_en = 1'b0;
  logic        cap_start_left = 1'b1;
  logic [31:0] tx_word = '0;
  logic        tx_word_avail = 1'b0;
  logic        tx_word_pop;
  logic        sf_req = 1'b0;
  logic        sf_req_left = 1'b0;
  logic        tx_sf_valid;
  logic [23:0] tx_aud;
  logic [3:0]  tx_pcuv;
  logic [3:0]  tx_pre;
  logic        rx_sf_valid = 1'b0;
  logic        rx_sf_left = 1'b0;
  logic [23:0] rx_aud = '0;
  logic [3:0]  rx_pcuv = '0;
  logic [3:0]  rx_pre = '0;
  logic        rx_push;
  logic [31:0] rx_word;

  always #(CLK_P/2) clk = ~clk;

  audio_word_fmt dut_i (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .pack_en(pack_en),
    .cap_en(cap_en), .cap_start_left(cap_start_left),
    .tx_word(tx_word), .tx_word_avail(tx_word_avail), .tx_word_pop(tx_word_pop),
    .sf_req(sf_req), .sf_req_left(sf_req_left), .tx_sf_valid(tx_sf_valid),
    .tx_aud(tx_aud), .tx_pcuv(tx_pcuv), .tx_pre(tx_pre),
    .rx_sf_valid(rx_sf_valid), .rx_sf_left(rx_sf_left), .rx_aud(rx_aud),
    .rx_pcuv(rx_pcuv), .rx_pre(rx_pre), .rx_push(rx_push), .rx_word(rx_word)
  );

  typedef struct {
    logic [23:0] aud;
    logic [3:0]  pcuv;
    logic [3:0]  pre;
    string       tag;
  } txe_t;
  typedef struct {
    logic [31:0] w;
    string       tag;
  } rxe_t;

  txe_t        txq[$];
  rxe_t        rxq[$];
  logic [31:0] fifo_q[$];
  int n_run = 0;
  int n_fail = 0;
  int n_pop = 0;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Scoreboard monitor: compares results as they appear
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_sf_valid) begin
        txe_t e;
        if (txq.size() == 0) chk(1'b0, "R8", "unexpected tx strobe", {8'h0, tx_aud}, 32'h0);
        else begin
          e = txq.pop_front();
          chk(tx_aud == e.aud, e.tag, "tx_aud", {8'h0, tx_aud}, {8'h0, e.aud});
          chk(tx_pcuv == e.pcuv, e.tag, "tx_pcuv", {28'h0, tx_pcuv}, {28'h0, e.pcuv});
          chk(tx_pre == e.pre, e.tag, "tx_pre", {28'h0, tx_pre}, {28'h0, e.pre});
        end
      end
      if (rx_push) begin
        rxe_t r;
        if (rxq.size() == 0) chk(1'b0, "R14", "unexpected rx push", rx_word, 32'h0);
        else begin
          r = rxq.pop_front();
          chk(rx_word == r.w, r.tag, "rx_word", rx_word, r.w);
        end
      end
    end
  end

  // Show-ahead FIFO model feeding the transmit side
  always @(posedge clk) begin
    if (!rst && tx_word_pop) begin
      n_pop++;
      if (fifo_q.size() == 0) chk(1'b0, "R8", "pop from empty fifo", 32'h0, 32'h0);
      else void'(fifo_q.pop_front());
    end
    tx_word_avail <= (fifo_q.size() != 0);
    tx_word       <= (fifo_q.size() != 0) ? fifo_q[0] : 32'h0;
  end

  task automatic load(logic [31:0] w);
    fifo_q.push_back(w);
    tx_word_avail = 1'b1;
    tx_word       = fifo_q[0];
  endtask

  task automatic exp_tx(logic [23:0] a, logic [3:0] f, logic [3:0] p, string tag);
    txe_t e;
    e.aud = a; e.pcuv = f; e.pre = p; e.tag = tag;
    txq.push_back(e);
  endtask

  task automatic exp_rx(logic [31:0] w, string tag);
    rxe_t r;
    r.w = w; r.tag = tag;
    rxq.push_back(r);
  endtask

  task automatic tx_sub(bit l, bit strobe_due, string tag);
    @(negedge clk);
    sf_req = 1'b1; sf_req_left = l;
    @(negedge clk);
    sf_req = 1'b0;
    chk(tx_sf_valid == strobe_due, tag, "tx_sf_valid timing", {31'h0, tx_sf_valid}, {31'h0, strobe_due});
  endtask

  task automatic rx_sub(bit l, logic [23:0] a, logic [3:0] f, logic [3:0] p, bit push_due, string tag);
    @(negedge clk);
    rx_sf_valid = 1'b1; rx_sf_left = l; rx_aud = a; rx_pcuv = f; rx_pre = p;
    @(negedge clk);
    rx_sf_valid = 1'b0;
    chk(rx_push == push_due, tag, "rx_push timing", {31'h0, rx_push}, {31'h0, push_due});
  endtask

  task automatic set_fmt(logic [1:0] f, bit p);
    @(negedge clk);
    fmt_sel = f; pack_en = p;
  endtask

  task automatic cap_restart(bit start_left);
    @(negedge clk);
    cap_en = 1'b0;
    @(negedge clk);
    cap_start_left = start_left;
    cap_en = 1'b1;
  endtask

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(tx_sf_valid == 1'b0, "R1", "tx_sf_valid", {31'h0, tx_sf_valid}, 32'h0);
    chk(rx_push == 1'b0, "R1", "rx_push", {31'h0, rx_push}, 32'h0);
    chk(tx_word_pop == 1'b0, "R1", "tx_word_pop", {31'h0, tx_word_pop}, 32'h0);
    chk(tx_aud == 24'h0, "R1", "tx_aud", {8'h0, tx_aud}, 32'h0);
    chk(rx_word == 32'h0, "R1", "rx_word", rx_word, 32'h0);

    // R2 24-bit transmit, one pop per subframe
    set_fmt(2'b10, 1'b0);
    load(32'h5A123456); load(32'hC3ABCDEF);
    p0 = n_pop;
    exp_tx(24'h123456, 4'h0, 4'h0, "R2"); tx_sub(1'b1, 1'b1, "R2");
    exp_tx(24'hABCDEF, 4'h0, 4'h0, "R2"); tx_sub(1'b0, 1'b1, "R2");
    chk(n_pop == p0 + 2, "R2", "pops", n_pop, p0 + 2);

    // R3 20-bit and 16-bit left justification, R4 zero flags outside raw
    set_fmt(2'b01, 1'b0);
    load(32'hFFFABCDE);
    exp_tx(24'hABCDE0, 4'h0, 4'h0, "R3"); tx_sub(1'b1, 1'b1, "R3");
    set_fmt(2'b00, 1'b0);
    load(32'hFFFFBEEF);
    exp_tx(24'hBEEF00, 4'h0, 4'h0, "R3"); tx_sub(1'b0, 1'b1, "R3");

    // R4 raw transmit
    set_fmt(2'b11, 1'b0);
    load(32'hA1234567);
    exp_tx(24'h123456, 4'hA, 4'h7, "R4"); tx_sub(1'b1, 1'b1, "R4");

    // R5 / R6 packed transmit, left first
    set_fmt(2'b00, 1'b1);
    load(32'h11112222); load(32'h33334444);
    p0 = n_pop;
    exp_tx(24'h222200, 4'h0, 4'h0, "R5"); tx_sub(1'b1, 1'b1, "R5");
    chk(n_pop == p0, "R6", "no pop after first half", n_pop, p0);
    exp_tx(24'h111100, 4'h0, 4'h0, "R5"); tx_sub(1'b0, 1'b1, "R5");
    chk(n_pop == p0 + 1, "R6", "pop after second half", n_pop, p0 + 1);
    // right half first
    exp_tx(24'h333300, 4'h0, 4'h0, "R5"); tx_sub(1'b0, 1'b1, "R5");
    chk(n_pop == p0 + 1, "R6", "no pop after right half", n_pop, p0 + 1);
    exp_tx(24'h444400, 4'h0, 4'h0, "R6"); tx_sub(1'b1, 1'b1, "R6");
    chk(n_pop == p0 + 2, "R6", "pop after left half", n_pop, p0 + 2);

    // R7 pack ignored with 24-bit format
    set_fmt(2'b10, 1'b1);
    load(32'h00ABCDEF); load(32'h00765432);
    p0 = n_pop;
    exp_tx(24'hABCDEF, 4'h0, 4'h0, "R7"); tx_sub(1'b1, 1'b1, "R7");
    exp_tx(24'h765432, 4'h0, 4'h0, "R7"); tx_sub(1'b0, 1'b1, "R7");
    chk(n_pop == p0 + 2, "R7", "pops with pack ignored", n_pop, p0 + 2);

    // R8 request with an empty FIFO
    p0 = n_pop;
    tx_sub(1'b1, 1'b0, "R8");
    chk(n_pop == p0, "R8", "no pop when empty", n_pop, p0);

    // R11 capture start on left, R9 24-bit receive
    set_fmt(2'b10, 1'b0);
    cap_restart(1'b1);
    rx_sub(1'b0, 24'h999999, 4'h1, 4'h1, 1'b0, "R11");
    exp_rx(32'h52123456, "R9"); rx_sub(1'b1, 24'h123456, 4'h5, 4'h2, 1'b1, "R14");
    exp_rx(32'hC1ABCDEF, "R11"); rx_sub(1'b0, 24'hABCDEF, 4'hC, 4'h1, 1'b1, "R11");

    // R9 16 and 20-bit receive
    set_fmt(2'b00, 1'b0);
    exp_rx(32'h3800BEEF, "R9"); rx_sub(1'b1, 24'hBEEF12, 4'h3, 4'h8, 1'b1, "R9");
    set_fmt(2'b01, 1'b0);
    exp_rx(32'h140ABCDE, "R9"); rx_sub(1'b0, 24'hABCDE5, 4'h1, 4'h4, 1'b1, "R9");

    // R10 raw receive
    set_fmt(2'b11, 1'b0);
    exp_rx(32'hA1234567, "R10"); rx_sub(1'b1, 24'h123456, 4'hA, 4'h7, 1'b1, "R10");

    // R7 pack ignored on receive with 20-bit format
    set_fmt(2'b01, 1'b1);
    exp_rx(32'h0F012345, "R7"); rx_sub(1'b1, 24'h123456, 4'h0, 4'hF, 1'b1, "R7");

    // R12 packed receive, start left then start right
    set_fmt(2'b00, 1'b1);
    cap_restart(1'b1);
    rx_sub(1'b1, 24'h2222AA, 4'h0, 4'h0, 1'b0, "R12");
    exp_rx(32'h11112222, "R12"); rx_sub(1'b0, 24'h1111BB, 4'h0, 4'h0, 1'b1, "R12");
    cap_restart(1'b0);
    rx_sub(1'b1, 24'h444400, 4'h0, 4'h0, 1'b0, "R11");
    rx_sub(1'b0, 24'h555500, 4'h0, 4'h0, 1'b0, "R12");
    exp_rx(32'h55556666, "R12"); rx_sub(1'b1, 24'h666600, 4'h0, 4'h0, 1'b1, "R12");

    // R13 lone subframe discarded, nothing pushed while disabled
    cap_restart(1'b1);
    rx_sub(1'b1, 24'h777700, 4'h0, 4'h0, 1'b0, "R13");
    @(negedge clk); cap_en = 1'b0;
    rx_sub(1'b0, 24'hDEAD00, 4'h0, 4'h0, 1'b0, "R13");
    rx_sub(1'b1, 24'hBEEF00, 4'h0, 4'h0, 1'b0, "R13");
    @(negedge clk); cap_start_left = 1'b0; cap_en = 1'b1;
    rx_sub(1'b0, 24'h888800, 4'h0, 4'h0, 1'b0, "R13");
    exp_rx(32'h88889999, "R13"); rx_sub(1'b1, 24'h999900, 4'h0, 4'h0, 1'b1, "R13");

    repeat (4) @(negedge clk);
    chk(txq.size() == 0, "R8", "tx scoreboard drained", txq.size(), 0);
    chk(rxq.size() == 0, "R14", "rx scoreboard drained", rxq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule